// File: doc/BRIEF.md
# Slave-Serial Configuration Sequencer

This block reconfigures a target FPGA over an 8-bit parallel pin port in slave-serial mode. The sequence starts with a start request. The block first sends a fixed kill pattern twice, which halts the design running on the target. It then pulses the program pin and polls the target's init-done pin at a fixed interval, giving up after a bounded number of tries. Once init is seen high, it shifts a configuration bitstream out on the data and clock pins.

The bitstream arrives as bytes on a valid/ready input. A flag on the final byte marks the end of the stream. Every pin state is held on the port for one step. The step length is a whole number of system clock cycles, derived from the clock frequency and the wanted step rate (750 kHz by default).

The port wiring passes through level shifters that invert some pins. A high clock pin is therefore the idle level as the target sees it. Between phases, and whenever the block is idle, the port shows only the clock pin high.

Top module: `sscfg_loader`

## Requirements
- R1: While reset is held and after it is released, `pin_out` is 0x01, and `busy`, `done`, `init_err` and `bs_ready` are all 0.
- R2: A start accepted while idle first drives 16 port steps. These are the 8-step kill pattern 0x84, 0x84, 0x88, 0x84, 0x88, 0x84, 0x88, 0x84, sent twice. Bit 7 is always set, and bit 2 or bit 3 alternates with it.
- R3: Directly after the kill steps come 10 program-pulse steps: 0x01, 0x03, 0x03, then 0x01 seven times. Bit 0 is the clock pin and bit 1 is the program pin.
- R4: After the pulse the port shows 0x01 and `bs_ready` stays 0. The synchronised init input is sampled once every POLL_MS milliseconds of clock cycles, up to POLL_TRIES times. The first sample found high starts the stream phase, with `bs_ready` rising in the cycle after that sample.
- R5: If no sample finds init high, `init_err` is set on the last poll edge. At that edge `busy` falls, `done` stays 0 and the port returns to 0x01.
- R6: Each accepted byte is sent most significant bit first. Each bit takes two steps: first bit 6 (data) equals the bit value with bit 0 (clock) high, then the same data with bit 0 low. The step values are 0x41/0x40 for a 1 and 0x01/0x00 for a 0.
- R7: `bs_ready` is 0 from the accepting edge until the 16th step of the byte has ended. In the cycle after that it returns to 1 (unless the byte was the last), and the port shows 0x01 until the next byte is accepted.
- R8: Every port step lasts exactly CLK_HZ/STEP_HZ clock cycles. The first step appears in the cycle after the start or byte is accepted.
- R9: When the 16th step of a byte that was accepted with `bs_last` high ends, `done` rises, `busy` falls and the port returns to 0x01.
- R10: A start request while `busy` is high has no effect on the port sequence or the status. A start accepted when idle clears `done` and `init_err`.
- R11: Bit 5 of `pin_out` (the init position, an input at the target side) is always driven 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a configuration run; taken only when idle |
| init_in | input | 1 | Init-done level read back from the target (asynchronous) |
| bs_data | input | 8 | Bitstream byte |
| bs_valid | input | 1 | `bs_data` and `bs_last` are valid |
| bs_last | input | 1 | This byte is the final byte of the bitstream |
| bs_ready | output | 1 | Sequencer takes a byte this cycle if `bs_valid` is high |
| pin_out | output | 8 | Pin states for the parallel port |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run finished after its last byte |
| init_err | output | 1 | The last run gave up waiting for init |

## Verification
The bench holds init low until just after a chosen poll, including the very last allowed one. It then counts the cycles until `bs_ready` rises. A poller that is off by one interval or one try either starts early or reports a timeout when it should have succeeded. Directed bytes such as 0x80, 0x01, 0x00 and 0xFF, along with random bytes, are compared step by step against expected pin states. This exposes a reversed bit order, swapped clock phases or a wrong step length. `bs_valid` is held high with junk data while a byte is being shifted, and stray start pulses arrive during the kill pattern and the stream. A design that pulled bytes early or restarted while busy would then show a broken pattern. The timeout run checks that the error appears on exactly the last poll edge and not one interval sooner.

// File: rtl/sscfg_pkg.sv
package sscfg_pkg;

    localparam int PIN_W    = 8;
    localparam int BYTE_W   = 8;

    // Port pin positions (behavioural: the target is wired to these)
    localparam int PIN_CLK  = 0;
    localparam int PIN_PROG = 1;
    localparam int PIN_K2   = 2;
    localparam int PIN_K3   = 3;
    localparam int PIN_INIT = 5;
    localparam int PIN_DIN  = 6;
    localparam int PIN_K7   = 7;

    localparam int KILL_STEPS   = 8;
    localparam int KILL_REPEATS = 2;
    localparam int PULSE_STEPS  = 10;
    localparam int PULSE_FIRST  = 1;   // first pulse step with program high
    localparam int PULSE_LAST   = 2;   // last pulse step with program high
    localparam int PREP_STEPS   = KILL_STEPS * KILL_REPEATS + PULSE_STEPS;

    typedef logic [PIN_W-1:0] pins_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PREP,
        ST_WAIT,
        ST_STREAM
    } seq_state_e;

    function automatic pins_t pin_bit(input int pos);
        return pins_t'(1) << pos;
    endfunction

    localparam pins_t IDLE_PINS = pins_t'(1) << PIN_CLK;

    // Pin state for preparation step idx (kill pattern, then program pulse)
    function automatic pins_t prep_pattern(input int idx);
        int    k;
        pins_t v;
        if (idx < KILL_STEPS * KILL_REPEATS) begin
            k = idx % KILL_STEPS;
            v = pin_bit(PIN_K7);
            if (k != 0 && (k % 2) == 0)
                v = v | pin_bit(PIN_K3);
            else
                v = v | pin_bit(PIN_K2);
        end else begin
            k = idx - KILL_STEPS * KILL_REPEATS;
            v = pin_bit(PIN_CLK);
            if (k >= PULSE_FIRST && k <= PULSE_LAST)
                v = v | pin_bit(PIN_PROG);
        end
        return v;
    endfunction

    // Pin state for one half of a serialised bit
    function automatic pins_t bit_pins(input logic b, input logic low_phase);
        pins_t v;
        v = '0;
        if (b)
            v = v | pin_bit(PIN_DIN);
        if (!low_phase)
            v = v | pin_bit(PIN_CLK);
        return v;
    endfunction

endpackage

// File: rtl/sscfg_pacer.sv
module sscfg_pacer #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/sscfg_init_poll.sv
module sscfg_init_poll #(
    parameter int INTERVAL = 1000,
    parameter int TRIES    = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic init_raw,
    output logic found,
    output logic timeout
);
    localparam int ICW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam int TCW = (TRIES > 1) ? $clog2(TRIES) : 1;
    localparam logic [ICW-1:0] I_LAST = ICW'(INTERVAL - 1);
    localparam logic [TCW-1:0] T_LAST = TCW'(TRIES - 1);

    logic           sync1, sync2;
    logic           active;
    logic [ICW-1:0] icnt;
    logic [TCW-1:0] tcnt;
    logic           poll_now;

    assign poll_now = active && (icnt == I_LAST);
    assign found    = poll_now && sync2;
    assign timeout  = poll_now && !sync2 && (tcnt == T_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1  <= 1'b0;
            sync2  <= 1'b0;
            active <= 1'b0;
            icnt   <= '0;
            tcnt   <= '0;
        end else begin
            sync1 <= init_raw;
            sync2 <= sync1;
            if (arm) begin
                active <= 1'b1;
                icnt   <= '0;
                tcnt   <= '0;
            end else if (active) begin
                if (poll_now) begin
                    icnt <= '0;
                    if (found || timeout)
                        active <= 1'b0;
                    else
                        tcnt <= tcnt + 1'b1;
                end else begin
                    icnt <= icnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sscfg_serializer.sv
module sscfg_serializer
    import sscfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic              accept,
    output logic              stream_end,
    output pins_t             pins
);
    localparam int BCW = $clog2(BYTE_W);
    localparam logic [BCW-1:0] B_LAST = BCW'(BYTE_W - 1);

    logic [BYTE_W-1:0] shreg;
    logic [BCW-1:0]    bitcnt;
    logic              low_phase;
    logic              full;
    logic              last_q;
    logic              byte_end;

    assign in_ready   = en && !full;
    assign accept     = in_ready && in_valid;
    assign byte_end   = full && tick && low_phase && (bitcnt == B_LAST);
    assign stream_end = byte_end && last_q;
    assign pins       = full ? bit_pins(shreg[BYTE_W-1], low_phase) : IDLE_PINS;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            bitcnt    <= '0;
            low_phase <= 1'b0;
            full      <= 1'b0;
            last_q    <= 1'b0;
        end else if (accept) begin
            shreg     <= in_data;
            bitcnt    <= '0;
            low_phase <= 1'b0;
            full      <= 1'b1;
            last_q    <= in_last;
        end else if (full && tick) begin
            if (!low_phase) begin
                low_phase <= 1'b1;
            end else if (bitcnt == B_LAST) begin
                full      <= 1'b0;
                low_phase <= 1'b0;
            end else begin
                bitcnt    <= bitcnt + 1'b1;
                shreg     <= {shreg[BYTE_W-2:0], 1'b0};
                low_phase <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sscfg_loader.sv
module sscfg_loader
    import sscfg_pkg::*;
#(
    parameter int CLK_HZ     = 100_000_000,
    parameter int STEP_HZ    = 750_000,
    parameter int POLL_MS    = 10,
    parameter int POLL_TRIES = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       init_in,
    input  logic [7:0] bs_data,
    input  logic       bs_valid,
    input  logic       bs_last,
    output logic       bs_ready,
    output logic [7:0] pin_out,
    output logic       busy,
    output logic       done,
    output logic       init_err
);
    localparam int STEP_DIV    = CLK_HZ / STEP_HZ;
    localparam int POLL_CYCLES = (CLK_HZ / 1000) * POLL_MS;
    localparam int IDX_W       = $clog2(PREP_STEPS);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PREP_STEPS - 1);

    seq_state_e       state;
    logic [IDX_W-1:0] prep_idx;
    logic             start_acc;
    logic             tick;
    logic             arm;
    logic             init_found;
    logic             init_timeout;
    logic             ser_accept;
    logic             ser_end;
    pins_t            ser_pins;

    assign start_acc = start && (state == ST_IDLE);
    assign arm       = (state == ST_PREP) && tick && (prep_idx == IDX_LAST);

    sscfg_pacer #(.DIV(STEP_DIV)) u_pacer (
        .clk   (clk),
        .rst   (rst),
        .clear (start_acc || ser_accept),
        .tick  (tick)
    );

    sscfg_init_poll #(.INTERVAL(POLL_CYCLES), .TRIES(POLL_TRIES)) u_poll (
        .clk      (clk),
        .rst      (rst),
        .arm      (arm),
        .init_raw (init_in),
        .found    (init_found),
        .timeout  (init_timeout)
    );

    sscfg_serializer u_ser (
        .clk        (clk),
        .rst        (rst),
        .en         (state == ST_STREAM),
        .tick       (tick),
        .in_data    (bs_data),
        .in_valid   (bs_valid),
        .in_last    (bs_last),
        .in_ready   (bs_ready),
        .accept     (ser_accept),
        .stream_end (ser_end),
        .pins       (ser_pins)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            prep_idx <= '0;
            done     <= 1'b0;
            init_err <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_acc) begin
                        state    <= ST_PREP;
                        prep_idx <= '0;
                        done     <= 1'b0;
                        init_err <= 1'b0;
                    end
                end
                ST_PREP: begin
                    if (tick) begin
                        if (prep_idx == IDX_LAST)
                            state <= ST_WAIT;
                        else
                            prep_idx <= prep_idx + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (init_found) begin
                        state <= ST_STREAM;
                    end else if (init_timeout) begin
                        state    <= ST_IDLE;
                        init_err <= 1'b1;
                    end
                end
                ST_STREAM: begin
                    if (ser_end) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state)
            ST_PREP:   pin_out = prep_pattern(int'(prep_idx));
            ST_STREAM: pin_out = ser_pins;
            default:   pin_out = IDLE_PINS;
        endcase
    end

    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/sscfg_loader_chk.sv
module sscfg_loader_chk (
    input logic       clk,
    input logic       rst,
    input logic       bs_ready,
    input logic [7:0] pin_out,
    input logic       busy,
    input logic       done,
    input logic       init_err
);
    // R11: init position never driven
    p_init_pin_low_r11: assert property (@(posedge clk) disable iff (rst)
        pin_out[5] == 1'b0);

    // R1 / R9: idle port shows clock only
    p_idle_pins_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> pin_out == 8'h01);

    // R5: error and completion never together
    p_status_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(done && init_err));

    // R7: bytes only taken during a run
    p_ready_in_run_r7: assert property (@(posedge clk) disable iff (rst)
        bs_ready |-> busy);

    // R10: a new run starts with cleared status
    p_clear_on_start_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (!done && !init_err));

    // R9: done appears only as the run ends
    p_done_ends_run_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (!busy && $past(busy)));
endmodule

bind sscfg_loader sscfg_loader_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bs_ready (bs_ready),
    .pin_out  (pin_out),
    .busy     (busy),
    .done     (done),
    .init_err (init_err)
);

// File: tb/sscfg_loader_bench.sv
module sscfg_loader_bench;
    localparam int CLK_HZ  = 3_000_000;
    localparam int STEP_HZ = 750_000;
    localparam int POLL_MS = 1;
    localparam int TRIES   = 10;
    localparam int DIV     = CLK_HZ / STEP_HZ;
    localparam int P       = (CLK_HZ / 1000) * POLL_MS;
    localparam int PREP    = 26;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic       init_in;
    logic [7:0] bs_data;
    logic       bs_valid;
    logic       bs_last;
    logic       bs_ready;
    logic [7:0] pin_out;
    logic       busy;
    logic       done;
    logic       init_err;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    sscfg_loader #(
        .CLK_HZ(CLK_HZ), .STEP_HZ(STEP_HZ), .POLL_MS(POLL_MS), .POLL_TRIES(TRIES)
    ) u_sscfg_loader (
        .clk(clk), .rst(rst), .start(start), .init_in(init_in),
        .bs_data(bs_data), .bs_valid(bs_valid), .bs_last(bs_last),
        .bs_ready(bs_ready), .pin_out(pin_out), .busy(busy),
        .done(done), .init_err(init_err)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 190000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int exp_prep(input int idx);
        int k;
        if (idx < 16) begin
            k = idx % 8;
            return (k != 0 && k % 2 == 0) ? 'h88 : 'h84;
        end
        k = idx - 16;
        return (k == 1 || k == 2) ? 'h03 : 'h01;
    endfunction

    function automatic int exp_bit(input logic b, input int low);
        return (b ? 'h40 : 0) | (low != 0 ? 0 : 'h01);
    endfunction

    task automatic run_prep(input bit inject);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10 busy after start", int'(busy), 1);
        check("R10 done cleared", int'(done), 0);
        check("R10 init_err cleared", int'(init_err), 0);
        for (int i = 0; i < PREP * DIV; i++) begin
            if (inject && i == 7)  start = 1'b1;
            if (inject && i == 9)  start = 1'b0;
            if (i < 16 * DIV)
                check("R2 kill step", int'(pin_out), exp_prep(i / DIV));
            else
                check("R3 pulse step", int'(pin_out), exp_prep(i / DIV));
            check("R11 init pin low", int'(pin_out[5]), 0);
            @(negedge clk);
        end
        check("R4 idle pins in wait", int'(pin_out), 'h01);
        check("R4 no ready in wait", int'(bs_ready), 0);
    endtask

    task automatic wait_init(input int poll_k);
        int n = 0;
        while (!bs_ready && n < TRIES * P + 10) begin
            if (n == (poll_k - 1) * P + P / 2) init_in = 1'b1;
            @(negedge clk);
            n++;
        end
        check("R4 init poll timing", n, poll_k * P);
        check("R4 busy in stream", int'(busy), 1);
    endtask

    task automatic send_byte(input logic [7:0] d, input bit last, input bit junk,
                             input bit inject);
        check("R7 ready before byte", int'(bs_ready), 1);
        bs_data  = d;
        bs_valid = 1'b1;
        bs_last  = last;
        @(negedge clk);
        bs_valid = junk;
        bs_data  = ~d;
        bs_last  = 1'b1;
        for (int i = 0; i < 16 * DIV; i++) begin
            if (inject && i == 3) start = 1'b1;
            if (inject && i == 5) start = 1'b0;
            check("R6 R8 bit step", int'(pin_out),
                  exp_bit(d[7 - i / (2 * DIV)], (i / DIV) % 2));
            check("R7 ready low while shifting", int'(bs_ready), 0);
            @(negedge clk);
        end
        bs_valid = 1'b0;
        bs_last  = 1'b0;
        check("R7 idle pins after byte", int'(pin_out), 'h01);
        if (last) begin
            check("R9 done after last", int'(done), 1);
            check("R9 busy cleared", int'(busy), 0);
            check("R9 no ready after last", int'(bs_ready), 0);
        end else begin
            check("R7 ready after byte", int'(bs_ready), 1);
            check("R9 not done mid stream", int'(done), 0);
        end
    endtask

    initial begin
        logic [7:0] dir [5];
        int gap;
        void'($urandom(32'd4242));
        dir[0] = 8'hA5; dir[1] = 8'h00; dir[2] = 8'hFF; dir[3] = 8'h80; dir[4] = 8'h01;
        rst = 1'b1; start = 1'b0; init_in = 1'b0;
        bs_data = '0; bs_valid = 1'b0; bs_last = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset pins", int'(pin_out), 'h01);
        check("R1 reset busy", int'(busy), 0);
        check("R1 reset done", int'(done), 0);
        check("R1 reset err", int'(init_err), 0);
        check("R1 reset ready", int'(bs_ready), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset pins", int'(pin_out), 'h01);

        // Run 1: success on third poll, directed then random bytes
        run_prep(1'b1);
        wait_init(3);
        for (int b = 0; b < 5; b++)
            send_byte(dir[b], 1'b0, b[0], b == 2);
        for (int b = 0; b < 5; b++) begin
            gap = $urandom_range(0, 5);
            for (int g = 0; g < gap; g++) begin
                check("R7 idle pins between bytes", int'(pin_out), 'h01);
                @(negedge clk);
            end
            send_byte(8'($urandom), b == 4, 1'b1, 1'b0);
        end

        // Run 2: init never seen
        init_in = 1'b0;
        run_prep(1'b0);
        repeat (TRIES * P - 1) @(negedge clk);
        check("R5 no error before last poll", int'(init_err), 0);
        check("R5 busy before last poll", int'(busy), 1);
        check("R4 no ready without init", int'(bs_ready), 0);
        @(negedge clk);
        check("R5 error on last poll", int'(init_err), 1);
        check("R5 busy cleared", int'(busy), 0);
        check("R5 done stays low", int'(done), 0);
        check("R5 idle pins", int'(pin_out), 'h01);

        // Run 3: init seen on the very last allowed poll
        run_prep(1'b0);
        wait_init(TRIES);
        send_byte(8'($urandom), 1'b0, 1'b1, 1'b0);
        send_byte(8'($urandom), 1'b1, 1'b0, 1'b0);
        check("R9 no error on success", int'(init_err), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule